// File: doc/BRIEF.md
# Transceiver Enable State Machine

This block holds the operating state of a radio transceiver and turns that state into the enables for the baseband clocks, the transmit and receive synthesizers, and the transmit and receive signal chains. There are six states: a deep power-down state with the baseband clocks stopped, a power-save state with clocks running and synthesizers off, a ready state with both synthesizers running, a transmit state, a receive state and a full-duplex state with both chains active.

The state can be moved in two ways. The first is a command from a control bus: the bus presents the requested state and flips a toggle line. The toggle comes from another clock domain, so it is synchronized before use. The second is a pair of real-time pins, an enable and a transmit-not-receive select. They are synchronized and edge detected, and the enable acts either as a pulse or as a level. A duplex select picks time-division or frequency-division operation. In frequency-division pin mode a remap select turns the two pins into independent receive-on and transmit-on controls. There is no data stream through the block, so every port is a plain control or status signal with no handshake.

Top module: `trx_enable_fsm`

## Requirements
- R1: Reset (active-low `rst_n`) puts the state in Sleep with every enable low. State codes on `state_code`: Sleep=0, Wait=1, Alert=2, Tx=3, Rx=4, Fdd=5. No other code ever appears.
- R2: The outputs are decoded from the state as `{bbclk_en,synth_tx_en,synth_rx_en,tx_chain_en,rx_chain_en}`: Sleep 00000, Wait 10000, Alert 11100, Tx 11010, Rx 10101, Fdd 11111. Both chain enables are high together only in Fdd.
- R3: When `pin_ctrl_sel`=0, each change of `cmd_toggle` asks for the state on `cmd_state`. A legal request takes effect on the third rising clock edge after the toggle changes. Legal moves are Sleep↔Wait, Wait↔Alert, Alert→Tx/Rx/Fdd and Tx/Rx/Fdd→Alert. Any other request is ignored.
- R4: Sleep is left only for Wait, and only by command. A request from Alert straight to Sleep, or from Sleep straight to Alert, is ignored.
- R5: When `pin_ctrl_sel`=0, activity on `pin_enable` and `pin_txnrx` does not change the state.
- R6: In pin mode with `fdd_sel`=0 and `en_level_sel`=0, a rising edge on the enable pin moves Alert to Tx if `pin_txnrx`=1, or to Rx if `pin_txnrx`=0. The next rising edge returns Tx or Rx to Alert.
- R7: In pin mode with `en_level_sel`=1, a rising edge on the enable pin leaves Alert as in R6 or R8, and a falling edge returns to Alert. A change on `pin_txnrx` while active does not change the state.
- R8: In pin mode with `fdd_sel`=1 and `fdd_remap_sel`=0, enable events move Alert to Fdd and Fdd back to Alert, using the same pulse or level rule.
- R9: In pin mode with `fdd_sel`=1 and `fdd_remap_sel`=1, Alert goes to Fdd while either pin is high, and Fdd returns to Alert when both are low. In Fdd, `rx_chain_en` follows the enable pin and `tx_chain_en` follows `pin_txnrx`. Both synthesizers stay on.
- R10: An enable pulse that is high across a single rising clock edge is recognized.
- R11: In pin mode, commands act only among Sleep, Wait and Alert. Command requests into or out of Tx, Rx or Fdd are ignored.
- R12: Fdd is entered only when `fdd_sel`=1, and Tx or Rx only when `fdd_sel`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State-machine clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_toggle | input | 1 | Command request; each change is one command (asynchronous) |
| cmd_state | input | 3 | Requested state code, held stable around a toggle |
| pin_enable | input | 1 | Real-time enable pin, or receive-on when remapped |
| pin_txnrx | input | 1 | Transmit-not-receive pin, or transmit-on when remapped |
| pin_ctrl_sel | input | 1 | 1: pin control, 0: command control |
| fdd_sel | input | 1 | 1: frequency-division duplex, 0: time-division |
| en_level_sel | input | 1 | 1: enable pin is a level, 0: a pulse |
| fdd_remap_sel | input | 1 | 1: pins act as independent receive-on and transmit-on in FDD pin mode |
| state_code | output | 3 | Current state code |
| tx_chain_en | output | 1 | Transmit chain enable |
| rx_chain_en | output | 1 | Receive chain enable |
| synth_tx_en | output | 1 | Transmit synthesizer enable |
| synth_rx_en | output | 1 | Receive synthesizer enable |
| bbclk_en | output | 1 | Baseband clock enable |

## Verification
The assertions assume that `cmd_state` holds steady from a toggle change until the command has been taken. They also assume that `cmd_toggle` and both pins are low while reset is asserted, because a level left high through reset would look like a fresh edge once reset releases. The configuration selects are treated as quasi-static, and the properties on duplex entry compare against the select value seen on the edge that takes the state. The bench changes every input on the falling clock edge. It clears the toggle and the pins before each reset, and it holds each command and pin setting for several cycles before it checks the result, so every synchronized event settles inside that window.

// File: rtl/ensm_pkg.sv
package ensm_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_SLEEP = 3'd0,
    ST_WAIT  = 3'd1,
    ST_ALERT = 3'd2,
    ST_TX    = 3'd3,
    ST_RX    = 3'd4,
    ST_FDD   = 3'd5
  } ensm_state_e;

  typedef struct packed {
    logic bbclk;
    logic synth_tx;
    logic synth_rx;
    logic tx_chain;
    logic rx_chain;
  } ensm_en_t;

  function automatic logic is_active(ensm_state_e s);
    return (s == ST_TX) || (s == ST_RX) || (s == ST_FDD);
  endfunction
endpackage

// File: rtl/ensm_sync.sv
module ensm_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[g] <= '0;
        else        chain[g] <= d_async;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[g] <= '0;
        else        chain[g] <= chain[g-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/ensm_edge.sv
module ensm_edge #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] prev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= '0;
    else        prev <= lvl;

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/ensm_next.sv
module ensm_next
  import ensm_pkg::*;
(
  input  ensm_state_e cur,
  input  logic        cmd_evt,
  input  ensm_state_e cmd_req,
  input  logic        pin_ctrl,
  input  logic        fdd,
  input  logic        level_mode,
  input  logic        remap,
  input  logic        en_s,
  input  logic        txn_s,
  input  logic        en_rise,
  input  logic        en_fall,
  output ensm_state_e nxt
);
  logic cmd_ok;
  logic stop_evt;

  always_comb begin
    cmd_ok = 1'b0;
    unique case (cur)
      ST_SLEEP: cmd_ok = (cmd_req == ST_WAIT);
      ST_WAIT:  cmd_ok = (cmd_req == ST_SLEEP) || (cmd_req == ST_ALERT);
      ST_ALERT: cmd_ok = (cmd_req == ST_WAIT) ||
                         (!pin_ctrl && !fdd && ((cmd_req == ST_TX) || (cmd_req == ST_RX))) ||
                         (!pin_ctrl && fdd && (cmd_req == ST_FDD));
      ST_TX, ST_RX, ST_FDD: cmd_ok = !pin_ctrl && (cmd_req == ST_ALERT);
      default:  cmd_ok = 1'b0;
    endcase
  end

  assign stop_evt = level_mode ? en_fall : en_rise;

  always_comb begin
    nxt = cur;
    if (cmd_evt && cmd_ok) begin
      nxt = cmd_req;
    end else if (pin_ctrl) begin
      if (fdd && remap) begin
        if (cur == ST_ALERT && (en_s || txn_s))          nxt = ST_FDD;
        else if (cur == ST_FDD && !en_s && !txn_s)        nxt = ST_ALERT;
      end else begin
        if (cur == ST_ALERT && en_rise)
          nxt = fdd ? ST_FDD : (txn_s ? ST_TX : ST_RX);
        else if (is_active(cur) && stop_evt)
          nxt = ST_ALERT;
      end
    end
  end
endmodule

// File: rtl/ensm_outdec.sv
module ensm_outdec
  import ensm_pkg::*;
(
  input  ensm_state_e st,
  input  logic        remap_act,
  input  logic        rx_on,
  input  logic        tx_on,
  output ensm_en_t    en
);
  always_comb begin
    en = '0;
    unique case (st)
      ST_SLEEP: en = '0;
      ST_WAIT:  en.bbclk = 1'b1;
      ST_ALERT: begin
        en.bbclk    = 1'b1;
        en.synth_tx = 1'b1;
        en.synth_rx = 1'b1;
      end
      ST_TX: begin
        en.bbclk    = 1'b1;
        en.synth_tx = 1'b1;
        en.tx_chain = 1'b1;
      end
      ST_RX: begin
        en.bbclk    = 1'b1;
        en.synth_rx = 1'b1;
        en.rx_chain = 1'b1;
      end
      ST_FDD: begin
        en.bbclk    = 1'b1;
        en.synth_tx = 1'b1;
        en.synth_rx = 1'b1;
        en.tx_chain = remap_act ? tx_on : 1'b1;
        en.rx_chain = remap_act ? rx_on : 1'b1;
      end
      default: en = '0;
    endcase
  end
endmodule

// File: rtl/trx_enable_fsm.sv
module trx_enable_fsm
  import ensm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_toggle,
  input  logic [STATE_W-1:0] cmd_state,
  input  logic               pin_enable,
  input  logic               pin_txnrx,
  input  logic               pin_ctrl_sel,
  input  logic               fdd_sel,
  input  logic               en_level_sel,
  input  logic               fdd_remap_sel,
  output logic [STATE_W-1:0] state_code,
  output logic               tx_chain_en,
  output logic               rx_chain_en,
  output logic               synth_tx_en,
  output logic               synth_rx_en,
  output logic               bbclk_en
);
  localparam int NSIG  = 3;
  localparam int B_CMD = 0;
  localparam int B_EN  = 1;
  localparam int B_TXN = 2;

  logic [NSIG-1:0] raw_in, synced, rise, fall;
  ensm_state_e     cur_q, nxt;
  ensm_en_t        en;
  logic            cmd_evt;

  assign raw_in = {pin_txnrx, pin_enable, cmd_toggle};

  ensm_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(raw_in), .q_sync(synced)
  );

  ensm_edge #(.WIDTH(NSIG)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(synced), .rise(rise), .fall(fall)
  );

  assign cmd_evt = rise[B_CMD] | fall[B_CMD];

  ensm_next u_next (
    .cur       (cur_q),
    .cmd_evt   (cmd_evt),
    .cmd_req   (ensm_state_e'(cmd_state)),
    .pin_ctrl  (pin_ctrl_sel),
    .fdd       (fdd_sel),
    .level_mode(en_level_sel),
    .remap     (fdd_remap_sel),
    .en_s      (synced[B_EN]),
    .txn_s     (synced[B_TXN]),
    .en_rise   (rise[B_EN]),
    .en_fall   (fall[B_EN]),
    .nxt       (nxt)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cur_q <= ST_SLEEP;
    else        cur_q <= nxt;

  ensm_outdec u_dec (
    .st       (cur_q),
    .remap_act(pin_ctrl_sel & fdd_sel & fdd_remap_sel),
    .rx_on    (synced[B_EN]),
    .tx_on    (synced[B_TXN]),
    .en       (en)
  );

  assign state_code  = cur_q;
  assign bbclk_en    = en.bbclk;
  assign synth_tx_en = en.synth_tx;
  assign synth_rx_en = en.synth_rx;
  assign tx_chain_en = en.tx_chain;
  assign rx_chain_en = en.rx_chain;
endmodule

// File: rtl/trx_enable_fsm_chk.sv
module trx_enable_fsm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fdd_sel,
  input logic [2:0] state_code,
  input logic       tx_chain_en,
  input logic       rx_chain_en,
  input logic       synth_tx_en,
  input logic       synth_rx_en,
  input logic       bbclk_en
);
  assert_state_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    state_code <= 3'd5);

  assert_sleep_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd0) |-> !(bbclk_en | synth_tx_en | synth_rx_en | tx_chain_en | rx_chain_en));

  assert_dual_chain_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_chain_en && rx_chain_en) |-> (state_code == 3'd5));

  assert_sleep_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd0) |=> (state_code == 3'd0 || state_code == 3'd1));

  assert_alert_no_sleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd2) |=> (state_code != 3'd0));

  assert_fdd_entry_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code != 3'd5 && !fdd_sel) |=> (state_code != 3'd5));

  assert_tdd_entry_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd2 && fdd_sel) |=> (state_code != 3'd3 && state_code != 3'd4));
endmodule

bind trx_enable_fsm trx_enable_fsm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fdd_sel(fdd_sel), .state_code(state_code),
  .tx_chain_en(tx_chain_en), .rx_chain_en(rx_chain_en),
  .synth_tx_en(synth_tx_en), .synth_rx_en(synth_rx_en), .bbclk_en(bbclk_en)
);

// File: tb/sim_trx_enable_fsm.sv
`timescale 1ns/1ps
module sim_trx_enable_fsm;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_toggle = 1'b0;
  logic [2:0] cmd_state = 3'd0;
  logic pin_enable = 1'b0, pin_txnrx = 1'b0;
  logic pin_ctrl_sel = 1'b0, fdd_sel = 1'b0, en_level_sel = 1'b0, fdd_remap_sel = 1'b0;
  logic [2:0] state_code;
  logic tx_chain_en, rx_chain_en, synth_tx_en, synth_rx_en, bbclk_en;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trx_enable_fsm u0 (
    .clk(clk), .rst_n(rst_n), .cmd_toggle(cmd_toggle), .cmd_state(cmd_state),
    .pin_enable(pin_enable), .pin_txnrx(pin_txnrx), .pin_ctrl_sel(pin_ctrl_sel),
    .fdd_sel(fdd_sel), .en_level_sel(en_level_sel), .fdd_remap_sel(fdd_remap_sel),
    .state_code(state_code), .tx_chain_en(tx_chain_en), .rx_chain_en(rx_chain_en),
    .synth_tx_en(synth_tx_en), .synth_rx_en(synth_rx_en), .bbclk_en(bbclk_en)
  );

  // vector: {pin,fdd,lvl,remap}[13:10] op[9:8] cmd[7:5] en[4] txn[3] exp[2:0]
  // op 0: command, 1: pin levels only, 2: one-cycle enable pulse
  localparam int NV = 33;
  localparam logic [13:0] VECS [NV] = '{
    {4'b0000, 2'd0, 3'd1, 2'b00, 3'd1},  // R3 Sleep->Wait
    {4'b0000, 2'd0, 3'd2, 2'b00, 3'd2},  // R3 Wait->Alert
    {4'b0000, 2'd0, 3'd0, 2'b00, 3'd2},  // R4 Alert->Sleep ignored
    {4'b0000, 2'd0, 3'd3, 2'b00, 3'd3},  // R3 Alert->Tx
    {4'b0000, 2'd0, 3'd4, 2'b00, 3'd3},  // R3 Tx->Rx ignored
    {4'b0000, 2'd0, 3'd5, 2'b00, 3'd3},  // R3 Tx->Fdd ignored
    {4'b0000, 2'd0, 3'd2, 2'b00, 3'd2},  // R3 Tx->Alert
    {4'b0000, 2'd0, 3'd5, 2'b00, 3'd2},  // R12 Fdd refused in TDD
    {4'b0000, 2'd0, 3'd4, 2'b00, 3'd4},  // R3 Alert->Rx
    {4'b0000, 2'd1, 3'd0, 2'b11, 3'd4},  // R5 pins ignored
    {4'b0000, 2'd0, 3'd2, 2'b00, 3'd2},  // R3 Rx->Alert
    {4'b1000, 2'd2, 3'd0, 2'b01, 3'd3},  // R6 R10 pulse, txn=1 -> Tx
    {4'b1000, 2'd2, 3'd0, 2'b01, 3'd2},  // R6 pulse -> Alert
    {4'b1000, 2'd2, 3'd0, 2'b00, 3'd4},  // R6 pulse, txn=0 -> Rx
    {4'b1000, 2'd0, 3'd2, 2'b00, 3'd4},  // R11 command out of Rx ignored
    {4'b1000, 2'd2, 3'd0, 2'b00, 3'd2},  // R6 pulse -> Alert
    {4'b1000, 2'd0, 3'd3, 2'b00, 3'd2},  // R11 command into Tx ignored
    {4'b1010, 2'd1, 3'd0, 2'b11, 3'd3},  // R7 level rise, txn=1 -> Tx
    {4'b1010, 2'd1, 3'd0, 2'b10, 3'd3},  // R7 txn change ignored
    {4'b1010, 2'd1, 3'd0, 2'b00, 3'd2},  // R7 fall -> Alert
    {4'b1010, 2'd1, 3'd0, 2'b10, 3'd4},  // R7 rise, txn=0 -> Rx
    {4'b1010, 2'd1, 3'd0, 2'b00, 3'd2},  // R7 fall -> Alert
    {4'b1100, 2'd2, 3'd0, 2'b00, 3'd5},  // R8 pulse -> Fdd
    {4'b1100, 2'd2, 3'd0, 2'b00, 3'd2},  // R8 pulse -> Alert
    {4'b1110, 2'd1, 3'd0, 2'b10, 3'd5},  // R8 level rise -> Fdd
    {4'b1110, 2'd1, 3'd0, 2'b00, 3'd2},  // R8 level fall -> Alert
    {4'b0100, 2'd0, 3'd3, 2'b00, 3'd2},  // R12 Tx refused in FDD
    {4'b0100, 2'd0, 3'd5, 2'b00, 3'd5},  // R3 Alert->Fdd
    {4'b0100, 2'd0, 3'd2, 2'b00, 3'd2},  // R3 Fdd->Alert
    {4'b0100, 2'd0, 3'd1, 2'b00, 3'd1},  // R3 Alert->Wait
    {4'b0100, 2'd0, 3'd0, 2'b00, 3'd0},  // R4 Wait->Sleep
    {4'b0100, 2'd0, 3'd2, 2'b00, 3'd0},  // R4 Sleep->Alert ignored
    {4'b0100, 2'd0, 3'd1, 2'b00, 3'd1}   // R4 Sleep->Wait
  };

  function automatic logic [4:0] exp_en(input logic [2:0] s);
    case (s)
      3'd1:    return 5'b10000;
      3'd2:    return 5'b11100;
      3'd3:    return 5'b11010;
      3'd4:    return 5'b10101;
      3'd5:    return 5'b11111;
      default: return 5'b00000;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {bbclk_en, synth_tx_en, synth_rx_en, tx_chain_en, rx_chain_en};
  endfunction

  task automatic cmd(input logic [2:0] s);
    @(negedge clk);
    cmd_state  = s;
    cmd_toggle = ~cmd_toggle;
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset state", state_code, 0);
    check("R1 reset enables", outs(), 5'b00000);
    rst_n = 1'b1;
    settle();
    check("R1 idle after reset", state_code, 0);

    for (int i = 0; i < NV; i++) begin
      logic [13:0] v;
      v = VECS[i];
      @(negedge clk);
      {pin_ctrl_sel, fdd_sel, en_level_sel, fdd_remap_sel} = v[13:10];
      pin_enable = v[4];
      pin_txnrx  = v[3];
      if (v[9:8] == 2'd0) begin
        cmd_state  = v[7:5];
        cmd_toggle = ~cmd_toggle;
      end else if (v[9:8] == 2'd2) begin
        pin_enable = 1'b1;
        @(negedge clk);
        pin_enable = 1'b0;
      end
      settle();
      check($sformatf("R3/R12 vector %0d state", i), state_code, v[2:0]);
      check($sformatf("R2 vector %0d enables", i), outs(), exp_en(v[2:0]));
    end

    // R3: latency of a command, from Wait to Alert
    cmd(3'd2);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R3 no change after two edges", state_code, 1);
    @(posedge clk);
    @(negedge clk);
    check("R3 change on third edge", state_code, 2);

    // R9: remapped FDD pins
    @(negedge clk);
    {pin_ctrl_sel, fdd_sel, en_level_sel, fdd_remap_sel} = 4'b1101;
    pin_enable = 1'b1;
    pin_txnrx  = 1'b0;
    settle();
    check("R9 rx-on enters Fdd", state_code, 5);
    check("R9 rx only", outs(), 5'b11101);
    @(negedge clk);
    pin_enable = 1'b0;
    pin_txnrx  = 1'b1;
    settle();
    check("R9 tx-on keeps Fdd", state_code, 5);
    check("R9 tx only", outs(), 5'b11110);
    @(negedge clk);
    pin_txnrx = 1'b0;
    settle();
    check("R9 both low returns to Alert", state_code, 2);
    check("R9 Alert enables", outs(), 5'b11100);

    // R1: reset in the middle of operation
    @(negedge clk);
    pin_txnrx = 1'b1;
    settle();
    check("R9 Fdd before reset", state_code, 5);
    @(negedge clk);
    pin_txnrx  = 1'b0;
    cmd_toggle = 1'b0;
    rst_n      = 1'b0;
    @(negedge clk);
    check("R1 reset from Fdd", state_code, 0);
    check("R1 reset enables off", outs(), 5'b00000);
    rst_n = 1'b1;
    settle();
    check("R4 Sleep held after reset", state_code, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule